// File: doc/BRIEF.md
# Inter-Processor Doorbell Register

This block holds a small set of sticky doorbell flags that let two processors interrupt each other. One side sets a flag by writing a one to the set port. That flag then drives an event line into the interrupt controller of the processor being signalled. The receiving side acknowledges the event by writing a one to the clear port. Writing a zero to either port leaves the flag as it was. The readback bus shows every flag at all times.

The five flags fan out unevenly. Flags 0 to 3 each raise an event toward processor A. Flags 2 and 3 also raise an event toward processor B, so a single write can reach both processors together. Flag 4 is used for nothing but a non-maskable event toward processor B. Every event output is a level that follows its stored flag.

Top module: `ipc_sig_regs`

## Requirements
- R1: While rst_n is low, and on the first edge after it goes low, every flag clears: rd_data, evt_a, evt_b and nmi_b are all zero.
- R2: A set_we write with a one in bit i of set_data sets flag i (i = 0..4) at that clock edge. Bits holding zero leave their flags unchanged.
- R3: A clr_we write with a one in bit i of clr_data clears flag i at that clock edge. Bits holding zero leave their flags unchanged.
- R4: If a set and a clear of the same flag fall on the same edge, the flag ends up set.
- R5: evt_a[i] equals flag i for i = 0..3.
- R6: evt_b[0] equals flag 2 and evt_b[1] equals flag 3.
- R7: nmi_b equals flag 4. Flag 4 drives no bit of evt_a or evt_b.
- R8: rd_data[4:0] carries flags 4..0 and rd_data[31:5] reads zero. Write data bits 31..5 have no effect on any output.
- R9: On an edge with neither set_we nor clr_we high, all flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_we | input | 1 | Write strobe for the set port |
| set_data | input | 32 | Set mask; a one in a bit sets that flag |
| clr_we | input | 1 | Write strobe for the clear port |
| clr_data | input | 32 | Clear mask; a one in a bit clears that flag |
| rd_data | output | 32 | Flag state, upper bits zero |
| evt_a | output | 4 | Level events toward processor A |
| evt_b | output | 2 | Level events toward processor B |
| nmi_b | output | 1 | Non-maskable level event toward processor B |

## Verification
A write is captured on the clock edge where its strobe is high. Its effect is visible on rd_data and on all event lines straight after that edge, because the outputs are combinational from the flag flops. The bench changes its inputs on the falling edge. It compares all outputs on the next falling edge, against a model that the bench has already advanced by the inputs it drove, so each comparison lands exactly one rising edge after the write it covers. Outputs are never sampled at a rising edge.

// File: rtl/ipc_sig_pkg.sv
package ipc_sig_pkg;
   // slot positions of the two write ports
   typedef enum logic [0:0] {
      PORT_SET = 1'b0,
      PORT_CLR = 1'b1
   } ipc_port_e;

   // mask of the low n bits
   function automatic logic [31:0] low_mask(input int n);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < n; i++) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/ipc_sig_wdec.sv
module ipc_sig_wdec #(
   parameter int DATA_W  = 32,
   parameter int NUM_SIG = 5
) (
   input  logic               we,
   input  logic [DATA_W-1:0]  data,
   output logic [NUM_SIG-1:0] pulse
);
   // only the implemented slice takes part; upper bits are dropped here
   assign pulse = we ? data[NUM_SIG-1:0] : '0;
endmodule

// File: rtl/ipc_sig_cell.sv
module ipc_sig_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;   // set dominates a same-edge clear
      else if (clr_i) q <= 1'b0;
   end
endmodule

// File: rtl/ipc_sig_route.sv
module ipc_sig_route #(
   parameter int NUM_SIG = 5,
   parameter int A_CNT   = 4,
   parameter int B_FIRST = 2,
   parameter int B_CNT   = 2,
   parameter int NMI_IDX = 4
) (
   input  logic [NUM_SIG-1:0] flags,
   output logic [A_CNT-1:0]   evt_a,
   output logic [B_CNT-1:0]   evt_b,
   output logic               nmi_b
);
   for (genvar i = 0; i < A_CNT; i++) begin : g_a
      assign evt_a[i] = flags[i];
   end
   for (genvar j = 0; j < B_CNT; j++) begin : g_b
      assign evt_b[j] = flags[B_FIRST + j];
   end
   assign nmi_b = flags[NMI_IDX];
endmodule

// File: rtl/ipc_sig_regs.sv
module ipc_sig_regs #(
   parameter int DATA_W  = 32,
   parameter int NUM_SIG = 5,
   parameter int A_CNT   = 4,
   parameter int B_FIRST = 2,
   parameter int B_CNT   = 2,
   parameter int NMI_IDX = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic [DATA_W-1:0] set_data,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] clr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [A_CNT-1:0]  evt_a,
   output logic [B_CNT-1:0]  evt_b,
   output logic              nmi_b
);
   localparam int PAD_W = DATA_W - NUM_SIG;

   if (NUM_SIG < 1 || NUM_SIG >= DATA_W) begin : g_bad_num
      $error("NUM_SIG must be between 1 and DATA_W-1");
   end
   if (A_CNT > NUM_SIG || B_FIRST + B_CNT > NUM_SIG) begin : g_bad_route
      $error("event routing exceeds flag count");
   end
   if (NMI_IDX >= NUM_SIG || NMI_IDX < A_CNT) begin : g_bad_nmi
      $error("NMI flag must be a flag outside the processor A range");
   end

   logic [NUM_SIG-1:0] set_p, clr_p, flags;

   ipc_sig_wdec #(.DATA_W(DATA_W), .NUM_SIG(NUM_SIG)) u_set_dec (
      .we(set_we), .data(set_data), .pulse(set_p));
   ipc_sig_wdec #(.DATA_W(DATA_W), .NUM_SIG(NUM_SIG)) u_clr_dec (
      .we(clr_we), .data(clr_data), .pulse(clr_p));

   for (genvar k = 0; k < NUM_SIG; k++) begin : g_flag
      ipc_sig_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .set_i(set_p[k]), .clr_i(clr_p[k]), .q(flags[k]));
   end

   ipc_sig_route #(
      .NUM_SIG(NUM_SIG), .A_CNT(A_CNT), .B_FIRST(B_FIRST),
      .B_CNT(B_CNT), .NMI_IDX(NMI_IDX)
   ) u_route (
      .flags(flags), .evt_a(evt_a), .evt_b(evt_b), .nmi_b(nmi_b));

   assign rd_data = {{PAD_W{1'b0}}, flags};
endmodule

// File: rtl/ipc_sig_chk.sv
module ipc_sig_chk #(
   parameter int DATA_W  = 32,
   parameter int NUM_SIG = 5,
   parameter int A_CNT   = 4,
   parameter int B_FIRST = 2,
   parameter int B_CNT   = 2,
   parameter int NMI_IDX = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              set_we,
   input logic [DATA_W-1:0] set_data,
   input logic              clr_we,
   input logic [DATA_W-1:0] clr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic [A_CNT-1:0]  evt_a,
   input logic [B_CNT-1:0]  evt_b,
   input logic              nmi_b
);
   localparam logic [DATA_W-1:0] IMPL = ipc_sig_pkg::low_mask(NUM_SIG);

   logic [DATA_W-1:0] set_m, clr_only_m;
   assign set_m      = set_we ? (set_data & IMPL) : '0;
   assign clr_only_m = clr_we ? (clr_data & IMPL & ~set_m) : '0;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (rd_data == '0));
   // R2
   set_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((rd_data & $past(set_m)) == $past(set_m)));
   // R3 and R4
   clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((rd_data & $past(clr_only_m)) == '0));
   // R5
   evt_a_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_a == rd_data[A_CNT-1:0]);
   // R6
   evt_b_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_b == rd_data[B_FIRST +: B_CNT]);
   // R7
   nmi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_b == rd_data[NMI_IDX]);
   // R8
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~IMPL) == '0);
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(rd_data));
endmodule

bind ipc_sig_regs ipc_sig_chk #(
   .DATA_W(DATA_W), .NUM_SIG(NUM_SIG), .A_CNT(A_CNT),
   .B_FIRST(B_FIRST), .B_CNT(B_CNT), .NMI_IDX(NMI_IDX)
) u_chk (.*);

// File: tb/ipc_sig_regs_bench.sv
module ipc_sig_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        set_we = 1'b0, clr_we = 1'b0;
   logic [31:0] set_data = '0, clr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  evt_a;
   logic [1:0]  evt_b;
   logic        nmi_b;

   int          n_chk = 0, n_bad = 0;
   logic [4:0]  exp_f = '0;
   bit          done = 0;

   always #2 clk = ~clk;

   ipc_sig_regs u_ipc_sig_regs (.*);

   function automatic logic [4:0] nxt(input logic [4:0] f,
      input logic sw, input logic [31:0] sd, input logic cw, input logic [31:0] cd);
      logic [4:0] s, c;
      s = sw ? sd[4:0] : 5'b0;
      c = cw ? cd[4:0] : 5'b0;
      return (f & ~c) | s;
   endfunction

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      cmp(tag, rd_data, {27'b0, exp_f});
      cmp("R5", {28'b0, evt_a}, {28'b0, exp_f[3:0]});
      cmp("R6", {30'b0, evt_b}, {30'b0, exp_f[3:2]});
      cmp("R7", {31'b0, nmi_b}, {31'b0, exp_f[4]});
   endtask

   // drive one cycle, then check on the following falling edge
   task automatic step(input string tag, input logic sw, input logic [31:0] sd,
                       input logic cw, input logic [31:0] cd);
      @(negedge clk);
      set_we = sw; set_data = sd; clr_we = cw; clr_data = cd;
      exp_f = nxt(exp_f, sw, sd, cw, cd);
      @(negedge clk);
      set_we = 1'b0; clr_we = 1'b0;
      check_all(tag);
   endtask

   initial begin
      void'($urandom(32'h1a2b3c4d));
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      // R2 set of flag 0 only; zeros elsewhere leave flags alone
      step("R2", 1, 32'h1, 0, 0);
      // R2 bits 2,3 reach both processors
      step("R2", 1, 32'hC, 0, 0);
      // R7 NMI flag alone
      step("R7", 1, 32'h10, 0, 0);
      // R9 idle cycles hold
      step("R9", 0, 32'h1F, 0, 32'h1F);
      // R3 clear flag 2 only
      step("R3", 0, 0, 1, 32'h4);
      // R4 same-edge set and clear of flag 1 and 3
      step("R4", 1, 32'hA, 1, 32'hA);
      // R8 upper write bits ignored
      step("R8", 1, 32'hFFFF_FFE0, 1, 32'hFFFF_FFE0);
      // R3 clear all
      step("R3", 0, 0, 1, 32'hFFFF_FFFF);
      for (int i = 0; i < 400; i++) begin
         step("R2/R3", ($urandom % 2) == 1, $urandom, ($urandom % 3) == 0, $urandom);
      end
      // R1 reset mid-run
      step("R2", 1, 32'h1F, 0, 0);
      @(negedge clk); rst_n = 1'b0; exp_f = '0;
      @(negedge clk); check_all("R1");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule